// File: doc/BRIEF.md
# Programmable Address Region Decoder

This block sorts every bus access into one of a set of software-programmed address windows. Each window is described by a single 32-bit descriptor. The descriptor holds a destination code and three attribute disables, for execute, cache and write. It also holds a page-size select, a size counted in pages and a start address counted in pages. For the current access address, the decoder reports whether any window matched, which one won, its destination code, and whether the access may be cached or executed. These are all combinational results of the address and the stored descriptors.

A write that lands in a window whose writes are disabled is blocked: the write-grant output stays low. The decoder also records the event as a pending violation together with the offending window number. The pending flag can drive an interrupt line when the interrupt is enabled in a control register. Software loads descriptors, the control register and the write-1-to-clear status through a plain register-write port that uses byte offsets.

Top module: `region_map_decoder`

## Requirements
- R1: After a synchronous active-low reset, every descriptor is zero, so no access hits. The violation flag, the recorded window number, the interrupt enable and the interrupt output are all zero.
- R2: A configuration write at byte offset 4*i, for i from 0 to 15, replaces the whole descriptor of window i. The new descriptor governs decoding from the next cycle onward.
- R3: Descriptor bit 25 set selects 64 KB pages. The window then covers start*64K up to and including (start+size+1)*64K - 1, where start is bits 13:0 and size is bits 24:14.
- R4: Descriptor bit 25 clear selects 4 KB pages, and the same start and size fields are scaled by 4 KB.
- R5: Bits 31:29 are reported as the destination code on a hit, with 3'b111 meaning SDRAM. A descriptor whose destination code is 3'b000 never matches.
- R6: When several windows contain the address, the lowest-numbered window is reported. On a miss, the window number and destination code read 0.
- R7: On a hit, the cacheable output is the inverse of bit 27 and the executable output is the inverse of bit 28. On a miss, both outputs are 0.
- R8: A write access is granted unless it hits a window with bit 26 set, in which case the grant stays low. A read never raises the grant.
- R9: A blocked write sets the violation flag on the next clock edge and records the window number. While the flag is set, later violations do not change the recorded number.
- R10: Writing 1 to bit 0 of the status register (offset 0x44) clears the flag, and writing 0 to it has no effect. If a blocked write arrives in the same cycle as the clear, the flag stays set and records the new window number.
- R11: The interrupt output is high exactly when the violation flag is set and bit 7 of the control register (offset 0x40) is set.
- R12: A window with the largest size field (2047) and 64 KB pages spans 128 MB. Its last byte hits and the byte just past it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Bus access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| hit | output | 1 | Some enabled window contains the address |
| hit_idx | output | 4 | Winning window number |
| hit_tgt | output | 3 | Destination code of the winning window |
| cacheable | output | 1 | Access may be cached |
| executable | output | 1 | Access may be executed |
| wr_grant | output | 1 | Write is allowed to proceed |
| viol_pend | output | 1 | Write-protect violation pending |
| viol_region | output | 4 | Window number of the recorded violation |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions check the following on every cycle:
- A granted write never lands in a write-disabled hit.
- Every blocked write raises the violation flag one cycle later.
- The recorded window number holds steady unless a clear is requested.
- A hit never reports destination code 0, and a miss never reports cacheable or executable.

The remaining properties need the bench's scenarios to show them. These are the exact window bounds under both page sizes, the lowest-number priority on overlaps, the clear-versus-set collision, and the full 128 MB window edge.

// File: rtl/rgn_pkg.sv
// Package: shared descriptor layout for the address region decoder.
// Assumes a 32-bit descriptor; field order is fixed because software builds it.
package rgn_pkg;

    typedef struct packed {
        logic [2:0]  tgt;     // destination code, 0 = window off
        logic        x_dis;   // execute disable
        logic        c_dis;   // cache disable
        logic        w_dis;   // write disable
        logic        pg_big;  // 1 = 64 KB pages, 0 = 4 KB pages
        logic [10:0] size;    // window length minus one, in pages
        logic [13:0] start;   // window base, in pages
    } rgn_desc_t;

    localparam int SMALL_PG_SH = 12;
    localparam int BIG_PG_SH   = 16;

endpackage

// File: rtl/rgn_regfile.sv
// Module: descriptor and control storage behind the byte-offset write port.
// Assumes descriptors at word offsets 0..NUM_REGIONS-1, control next, status after.
module rgn_regfile
    import rgn_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int CFG_AW      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output rgn_desc_t        desc_o [NUM_REGIONS],
    output logic             irq_en_o,
    output logic             clr_req_o
);
    localparam int WORD_W = CFG_AW - 2;
    localparam logic [WORD_W-1:0] CTL_WORD  = WORD_W'(NUM_REGIONS);
    localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(NUM_REGIONS + 1);

    logic [WORD_W-1:0] word;
    logic              unused_lo;

    assign word      = cfg_addr[CFG_AW-1:2];
    assign unused_lo = ^cfg_addr[1:0];

    // One storage register per window, replaced whole on a matching write.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_desc
        rgn_desc_t q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (cfg_we && word == WORD_W'(g))
                q <= rgn_desc_t'(cfg_wdata);
        end
        assign desc_o[g] = q;
    end

    // Interrupt enable bit of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_o <= 1'b0;
        else if (cfg_we && word == CTL_WORD)
            irq_en_o <= cfg_wdata[7];
    end

    // Write-1-to-clear request toward the violation latch.
    assign clr_req_o = cfg_we && (word == STAT_WORD) && cfg_wdata[0];

endmodule

// File: rtl/rgn_match.sv
// Module: range compare of one address against one window.
// Assumes start and size are page counts; page size picked by pg_big.
module rgn_match
    import rgn_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        tgt,
    input  logic              pg_big,
    input  logic [10:0]       size,
    input  logic [13:0]       start,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [4:0]       sh;
    logic [EXT_W-1:0] base, span, addr_x, ofs;

    // Scale fields to bytes and test base <= addr < base + span.
    always_comb begin
        sh     = pg_big ? 5'(BIG_PG_SH) : 5'(SMALL_PG_SH);
        base   = EXT_W'(start) << sh;
        span   = (EXT_W'(size) + EXT_W'(1)) << sh;
        addr_x = {1'b0, addr};
        ofs    = addr_x - base;
        hit    = (tgt != 3'b000) && (addr_x >= base) && (ofs < span);
    end

endmodule

// File: rtl/rgn_prio.sv
// Module: picks the lowest-numbered asserted hit.
// Assumes index reads 0 when nothing hits.
module rgn_prio #(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    // Scan downward so the last assignment is the lowest index.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rgn_viol.sv
// Module: write-protect violation latch with window number capture.
// Assumes a new violation in the clear cycle wins over the clear.
module rgn_viol #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol,
    input  logic [IDX_W-1:0] idx,
    input  logic             clr_req,
    output logic             pend,
    output logic [IDX_W-1:0] region
);
    // Capture first violation; hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            region <= '0;
        end else if (viol && (!pend || clr_req)) begin
            pend   <= 1'b1;
            region <= idx;
        end else if (clr_req) begin
            pend   <= 1'b0;
        end
    end

endmodule

// File: rtl/region_map_decoder.sv
// Module: top of the programmable address region decoder.
// Assumes a single access per cycle; decode results are combinational.
module region_map_decoder
    import rgn_pkg::*;
#(
    parameter int  NUM_REGIONS = 16,
    parameter int  ADDR_W      = 32,
    localparam int IDX_W       = $clog2(NUM_REGIONS),
    localparam int CFG_AW      = $clog2(NUM_REGIONS * 4 + 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [2:0]        hit_tgt,
    output logic              cacheable,
    output logic              executable,
    output logic              wr_grant,
    output logic              viol_pend,
    output logic [IDX_W-1:0]  viol_region,
    output logic              irq
);
    rgn_desc_t              desc [NUM_REGIONS];
    rgn_desc_t              sel_desc;
    logic [NUM_REGIONS-1:0] hits;
    logic                   irq_en, clr_req, viol, unused_sel;

    rgn_regfile #(.NUM_REGIONS(NUM_REGIONS), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .desc_o(desc), .irq_en_o(irq_en),
        .clr_req_o(clr_req)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        rgn_match #(.ADDR_W(ADDR_W)) u_m (
            .addr(acc_addr), .tgt(desc[g].tgt), .pg_big(desc[g].pg_big),
            .size(desc[g].size), .start(desc[g].start), .hit(hits[g])
        );
    end

    rgn_prio #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
        .hits(hits), .any(hit), .idx(hit_idx)
    );

    // Attributes of the winning window, gated to zero on a miss.
    always_comb begin
        sel_desc   = desc[hit_idx];
        hit_tgt    = hit ? sel_desc.tgt : 3'b000;
        cacheable  = hit && !sel_desc.c_dis;
        executable = hit && !sel_desc.x_dis;
        viol       = acc_valid && acc_write && hit && sel_desc.w_dis;
        wr_grant   = acc_valid && acc_write && !viol;
    end
    assign unused_sel = ^{sel_desc.pg_big, sel_desc.size, sel_desc.start};

    rgn_viol #(.IDX_W(IDX_W)) u_viol (
        .clk(clk), .rst_n(rst_n), .viol(viol), .idx(hit_idx),
        .clr_req(clr_req), .pend(viol_pend), .region(viol_region)
    );

    assign irq = viol_pend && irq_en;

endmodule

// File: rtl/rgn_checker.sv
// Module: protocol checks for region_map_decoder, attached by bind.
// Assumes sel_wdis and clr_req are the top's internal selected write-disable and clear request.
module rgn_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             hit,
    input logic [2:0]       hit_tgt,
    input logic             cacheable,
    input logic             executable,
    input logic             wr_grant,
    input logic             sel_wdis,
    input logic             clr_req,
    input logic             viol_pend,
    input logic [IDX_W-1:0] viol_region,
    input logic             irq
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!viol_pend && !irq && viol_region == '0));

    assert_tgt_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_tgt != 3'b000));

    assert_miss_no_attr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!cacheable && !executable));

    assert_no_protected_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> (acc_valid && acc_write && !(hit && sel_wdis)));

    assert_violation_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit && sel_wdis) |=> viol_pend);

    assert_region_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_pend && !clr_req) |=> (viol_pend && $stable(viol_region)));

endmodule

bind region_map_decoder rgn_checker #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .hit(hit), .hit_tgt(hit_tgt), .cacheable(cacheable),
    .executable(executable), .wr_grant(wr_grant), .sel_wdis(sel_desc.w_dis),
    .clr_req(clr_req), .viol_pend(viol_pend), .viol_region(viol_region),
    .irq(irq)
);

// File: tb/tb_region_map_decoder.sv
module tb_region_map_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;
    localparam logic [6:0] CTL_OFS  = 7'h40;
    localparam logic [6:0] STAT_OFS = 7'h44;

    // {addr, write, exp_hit, exp_idx, exp_tgt, exp_cache, exp_exec, exp_grant}
    localparam logic [43:0] VEC [NV] = '{
        {32'h0010_0000, 1'b0, 1'b1, 4'd0,  3'd7, 1'b1, 1'b0, 1'b0},
        {32'h0010_FFFF, 1'b0, 1'b1, 4'd0,  3'd7, 1'b1, 1'b0, 1'b0},
        {32'h0011_0000, 1'b0, 1'b1, 4'd1,  3'd2, 1'b0, 1'b1, 1'b0},
        {32'h0013_FFFF, 1'b1, 1'b1, 4'd1,  3'd2, 1'b0, 1'b1, 1'b1},
        {32'h0014_0000, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0},
        {32'h000F_FFFF, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0},
        {32'h0030_0000, 1'b0, 1'b1, 4'd2,  3'd1, 1'b1, 1'b1, 1'b0},
        {32'h0030_1FFF, 1'b0, 1'b1, 4'd2,  3'd1, 1'b1, 1'b1, 1'b0},
        {32'h0030_2000, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0},
        {32'h0050_0000, 1'b0, 1'b1, 4'd15, 3'd3, 1'b1, 1'b1, 1'b0},
        {32'h1000_0000, 1'b0, 1'b1, 4'd5,  3'd7, 1'b1, 1'b1, 1'b0},
        {32'h17FF_FFFF, 1'b1, 1'b1, 4'd5,  3'd7, 1'b1, 1'b1, 1'b1},
        {32'h1800_0000, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0},
        {32'h0FFF_FFFF, 1'b1, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        hit, cacheable, executable, wr_grant, viol_pend, irq;
    logic [3:0]  hit_idx, viol_region;
    logic [2:0]  hit_tgt;
    int          n_chk = 0;
    int          n_err = 0;

    region_map_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .hit(hit), .hit_idx(hit_idx), .hit_tgt(hit_tgt),
        .cacheable(cacheable), .executable(executable), .wr_grant(wr_grant),
        .viol_pend(viol_pend), .viol_region(viol_region), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive an access at a falling edge; combinational results are settled at once.
    task automatic drive_acc(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        #1;
    endtask

    task automatic end_acc();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0010_0000; #1;
        check("R1 hit", 32'(hit), 0);
        check("R1 pend", 32'(viol_pend), 0);
        check("R1 irq", 32'(irq), 0);
        acc_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R2..R5: load windows 0,1,2,3,5,15
        cfg_write(7'h00, 32'hF200_0010); // SDRAM, no exec, 64K, 1 page @0x00100000
        cfg_write(7'h04, 32'h4A00_C010); // tgt 2, no cache, 64K, 4 pages @0x00100000
        cfg_write(7'h08, 32'h2400_4300); // tgt 1, no write, 4K, 2 pages @0x00300000
        cfg_write(7'h0C, 32'h0200_0050); // tgt 0: off, @0x00500000
        cfg_write(7'h14, 32'hE3FF_D000); // SDRAM, 64K, 2048 pages @0x10000000
        cfg_write(7'h3C, 32'h6600_0050); // tgt 3, no write, 64K, 1 page @0x00500000

        // Table walk: R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            drive_acc(VEC[i][43:12], VEC[i][11]);
            check($sformatf("R3/R4/R12 hit v%0d", i), 32'(hit), 32'(VEC[i][10]));
            check($sformatf("R6 idx v%0d", i), 32'(hit_idx), 32'(VEC[i][9:6]));
            check($sformatf("R5 tgt v%0d", i), 32'(hit_tgt), 32'(VEC[i][5:3]));
            check($sformatf("R7 cache v%0d", i), 32'(cacheable), 32'(VEC[i][2]));
            check($sformatf("R7 exec v%0d", i), 32'(executable), 32'(VEC[i][1]));
            check($sformatf("R8 grant v%0d", i), 32'(wr_grant), 32'(VEC[i][0]));
            end_acc();
            check($sformatf("R9 no pend v%0d", i), 32'(viol_pend), 0);
        end

        // R8/R9: blocked write into window 2
        drive_acc(32'h0030_0010, 1'b1);
        check("R8 blocked", 32'(wr_grant), 0);
        end_acc();
        check("R9 pend", 32'(viol_pend), 1);
        check("R9 region", 32'(viol_region), 2);
        check("R11 irq off", 32'(irq), 0);

        cfg_write(CTL_OFS, 32'h0000_0080);
        check("R11 irq on", 32'(irq), 1);

        // R9: second violation keeps first number
        drive_acc(32'h0050_0000, 1'b1);
        check("R8 blocked w15", 32'(wr_grant), 0);
        end_acc();
        check("R9 held", 32'(viol_region), 2);

        // R10: writing 0 has no effect
        cfg_write(STAT_OFS, 32'h0000_0000);
        check("R10 w0", 32'(viol_pend), 1);

        // R10: clear and new violation in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = STAT_OFS; cfg_wdata = 32'h1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h0050_0000;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        check("R10 set wins", 32'(viol_pend), 1);
        check("R10 new region", 32'(viol_region), 15);

        cfg_write(STAT_OFS, 32'h0000_0001);
        check("R10 cleared", 32'(viol_pend), 0);
        check("R11 irq low", 32'(irq), 0);

        // R2/R6: rewrite window 0 off; window 1 now wins
        cfg_write(7'h00, 32'h0);
        drive_acc(32'h0010_0000, 1'b0);
        check("R2 rewrite hit", 32'(hit), 1);
        check("R6 fallback idx", 32'(hit_idx), 1);
        end_acc();

        // R1: reset mid-run wipes descriptors
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        drive_acc(32'h1000_0000, 1'b0);
        check("R1 wiped", 32'(hit), 0);
        end_acc();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule